// File: doc/BRIEF.md
# Successive-Approximation Phase Nulling Controller

This block drives a phase-nulling measurement loop. An external phase shifter takes a 12-bit control word, and a phase detector compares the shifted signal with the signal under test. A comparator reduces the detector error to one bit. The controller runs a binary search over the shifter word and reads off the word at the null as the measured phase.

An extra leading trial chooses which of the detector's two nulls the search heads for. That choice sits in its own flip-flop and drives a select output, so the result has 13 bits and spans a full turn of phase. The comparator and the ripple-null strobe pass through the same resynchronising pipeline, so they stay aligned. A decision sample is taken only on a strobe that marks the null of the detector's residual ripple, and only after a programmable settle interval following each trial update.

Each decision is normally a single sample. In averaging mode it is instead a majority vote over a window of strobe-aligned samples. A conversion of 13 trials fits a 50 to 100 kS/s rate at typical IF clocks.

Top module: `phase_null_sar`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is idle: busy_o=0, done_o=0, null_sel_o=0, ctrl_word_o=0x800 (mid-scale) and result_o=0.
- R2: A start_i pulse seen while idle begins a conversion. On the next cycle busy_o=1 and the trial code {null_sel_o, ctrl_word_o} is 0x1000, which is the null-select trial.
- R3: Trials run from code bit 12 (null select) down to bit 0. After each decision, the next code keeps the bits already decided, applies the current bit's outcome, sets the next lower bit, and leaves the bits below it at zero.
- R4: A resynchronised comparator high keeps the bit under trial, and a low clears it. With a comparator that reports high when the trial code is at or below a target, result_o equals that target.
- R5: The trial code changes only on a cycle that follows a resynchronised ripple-null strobe. At least settle_cycles_i+1 cycles pass between a code update and the sample that decides it. Comparator values away from the strobe have no effect.
- R6: With avg_en_i=1, each decision takes 4 strobe-aligned samples and keeps the bit only when more than 2 of them are high. A single wrong sample in a window does not change the result.
- R7: At the end of a conversion, done_o is high for exactly one cycle and busy_o is low. result_o changes only in the cycle done_o is high and holds until the next done.
- R8: start_i while busy_o=1 is ignored. The conversion in progress completes unchanged with a single done pulse.
- R9: When idle without start, the code stays at its last value, so after a conversion the shifter remains at the null found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request pulse |
| settle_cycles_i | input | 6 | Settle cycles after each trial update |
| avg_en_i | input | 1 | Majority-vote averaging enable |
| cmp_i | input | 1 | Comparator decision on detector error (asynchronous) |
| ripple_null_i | input | 1 | Strobe marking the null of the detector ripple |
| ctrl_word_o | output | 12 | Phase-shifter control word |
| null_sel_o | output | 1 | Null-select decision, bit 12 of the code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| result_o | output | 13 | Final phase code {null_sel, word} |

## Verification
Random 13-bit targets are run through a shifter model that lags the control word by several cycles. The comparator is driven with random values except on ripple-null strobes, which tells apart a design that samples only at the strobe after settling from one that samples early or off-strobe. The directed targets 0, 0x0FFF, 0x1000 and 0x1FFF pin the null-select boundary and the all-clear and all-keep search paths. A trial-by-trial monitor separates a wrong bit order from a wrong keep/clear decision. In averaging runs, every fourth strobe sample is inverted, so only a correct majority vote converges. A second start mid-conversion and a reset mid-conversion show that neither disturbs the result nor leaves stale state behind.

// File: rtl/phase_null_pkg.sv
package phase_null_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/phase_null_sync.sv
module phase_null_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/phase_null_vote.sv
module phase_null_vote #(
  parameter int AVG_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic avg_en_i,
  input  logic arm_i,     // sequencer waiting for a decision
  input  logic sample_i,  // strobe-aligned sample this cycle
  input  logic bit_i,
  output logic decide_o,
  output logic keep_o
);
  localparam int CNT_W = $clog2(AVG_N + 1);

  logic [CNT_W-1:0] n_q, ones_q, n_nxt, ones_nxt;
  logic             last;

  always_comb begin
    n_nxt    = n_q + CNT_W'(1);
    ones_nxt = ones_q + CNT_W'(bit_i);
    last     = !avg_en_i || (n_nxt == CNT_W'(AVG_N));
    decide_o = sample_i && last;
    if (avg_en_i) keep_o = ({1'b0, ones_nxt} << 1) > (CNT_W + 1)'(AVG_N);
    else          keep_o = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      ones_q <= '0;
    end else if (!arm_i || decide_o) begin
      n_q    <= '0;
      ones_q <= '0;
    end else if (sample_i) begin
      n_q    <= n_nxt;
      ones_q <= ones_nxt;
    end
  end
endmodule

// File: rtl/phase_null_seq.sv
module phase_null_seq
  import phase_null_pkg::*;
#(
  parameter int CODE_W   = 13,
  parameter int SETTLE_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                decide_i,
  input  logic                keep_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                busy_o,
  output logic                arm_o,
  output logic                done_o,
  output logic [CODE_W-1:0]   result_o
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] CODE_MID   = CODE_W'(1) << (CODE_W - 2);
  localparam logic [CODE_W-1:0] CODE_FIRST = CODE_W'(1) << (CODE_W - 1);

  seq_state_e          state_q;
  logic [CODE_W-1:0]   code_q, code_nxt, result_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SETTLE_W-1:0] settle_q, settle_len_q;
  logic                done_q;

  always_comb begin
    code_nxt = code_q;
    if (!keep_i) code_nxt[idx_q] = 1'b0;
    if (idx_q != '0) code_nxt[idx_q - IDX_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      code_q       <= CODE_MID;
      idx_q        <= '0;
      settle_q     <= '0;
      settle_len_q <= '0;
      done_q       <= 1'b0;
      result_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          code_q       <= CODE_FIRST;
          idx_q        <= IDX_W'(CODE_W - 1);
          settle_q     <= settle_i;
          settle_len_q <= settle_i;
          state_q      <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_q == '0) state_q <= ST_SAMPLE;
          else                settle_q <= settle_q - SETTLE_W'(1);
        end
        ST_SAMPLE: if (decide_i) begin
          code_q <= code_nxt;
          if (idx_q == '0) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            result_q <= code_nxt;
          end else begin
            idx_q    <= idx_q - IDX_W'(1);
            settle_q <= settle_len_q;
            state_q  <= ST_SETTLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o   = code_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign arm_o    = (state_q == ST_SAMPLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/phase_null_sar.sv
module phase_null_sar #(
  parameter int WORD_W      = 12,
  parameter int SETTLE_W    = 6,
  parameter int AVG_N       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = WORD_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                avg_en_i,
  input  logic                cmp_i,
  input  logic                ripple_null_i,
  output logic [WORD_W-1:0]   ctrl_word_o,
  output logic                null_sel_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [CODE_W-1:0]   result_o
);
  logic              null_dly, cmp_dly, arm, decide, keep;
  logic [CODE_W-1:0] code;

  // comparator and ripple strobe share one pipeline so they stay aligned
  phase_null_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ripple_null_i, cmp_i}),
    .q_o   ({null_dly, cmp_dly})
  );

  phase_null_vote #(.AVG_N(AVG_N)) u_vote (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .avg_en_i(avg_en_i),
    .arm_i   (arm),
    .sample_i(arm && null_dly),
    .bit_i   (cmp_dly),
    .decide_o(decide),
    .keep_o  (keep)
  );

  phase_null_seq #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .settle_i(settle_cycles_i),
    .decide_i(decide),
    .keep_i  (keep),
    .code_o  (code),
    .busy_o  (busy_o),
    .arm_o   (arm),
    .done_o  (done_o),
    .result_o(result_o)
  );

  assign null_sel_o  = code[CODE_W-1];
  assign ctrl_word_o = code[WORD_W-1:0];

  // R5
  code_on_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !null_dly) |=> $stable(code));
  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !null_dly) |=> (busy_o && $stable(code)));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(code)));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(result_o) |-> (done_o && !busy_o));
endmodule

// File: tb/phase_null_sar_tb.sv
module phase_null_sar_tb;
  localparam int LAG = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  settle_cycles_i = 6'd10;
  logic        avg_en_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic        ripple_null_i = 1'b0;
  logic [11:0] ctrl_word_o;
  logic        null_sel_o, busy_o, done_o;
  logic [12:0] result_o;

  phase_null_sar u_dut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  int rip_period = 3, rip_cnt = 0, strobe_cnt = 0;
  bit flip_en = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;
  logic [12:0] target = '0, prev_code = 13'h0800;
  logic [12:0] hist [0:LAG];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  function automatic int low_bit(input logic [12:0] c);
    for (int i = 0; i < 13; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic logic [12:0] next_trial(input logic [12:0] p, input logic [12:0] t);
    int k = low_bit(p);
    logic [12:0] n = p;
    if (p > t) n[k] = 1'b0;
    if (k > 0) n[k-1] = 1'b1;
    return n;
  endfunction

  // shifter/detector model, trial monitor, watchdog
  always @(negedge clk_i) begin
    logic [12:0] cur;
    bit nul;
    cur = {null_sel_o, ctrl_word_o};
    for (int i = LAG; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = cur;
    rip_cnt = (rip_cnt >= rip_period - 1) ? 0 : rip_cnt + 1;
    nul = (rip_cnt == 0);
    ripple_null_i <= nul;
    if (nul) begin
      cmp_i <= (hist[LAG] <= target) ^ (flip_en && (strobe_cnt % 4 == 3));
      strobe_cnt++;
    end else begin
      cmp_i <= 1'($urandom);
    end
    // R3 R4: each trial step follows the search order and decision rule
    if (rst_ni && busy_o && prev_busy && cur != prev_code)
      check(cur == next_trial(prev_code, target), "R3 trial step", cur, next_trial(prev_code, target));
    // R7: one-cycle done
    if (rst_ni && done_o && prev_done) check(1'b0, "R7 done width", 2, 1);
    if (rst_ni && done_o) done_cnt++;
    prev_busy = busy_o;
    prev_done = done_o;
    prev_code = cur;
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int i;
    for (i = 0; i < 4000 && !done_o; i++) @(negedge clk_i);
    check(done_o, {req, " done seen"}, done_o, 1);
    check(!busy_o, {req, " busy low at done"}, busy_o, 0);
  endtask

  task automatic convert(input logic [12:0] t, input bit avg, input int period, input string req);
    target = t; avg_en_i = avg; flip_en = avg; rip_period = period;
    @(negedge clk_i);
    pulse_start();
    wait_done(req);
    check(result_o == t, {req, " result"}, result_o, t);
  endtask

  initial begin
    int d0;
    logic [12:0] t;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i <= LAG; i++) hist[i] = 13'h0800;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check({null_sel_o, ctrl_word_o} == 13'h0800, "R1 reset code", {null_sel_o, ctrl_word_o}, 13'h0800);
    check(!busy_o && !done_o, "R1 reset flags", {busy_o, done_o}, 0);
    check(result_o == 0, "R1 reset result", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check({null_sel_o, ctrl_word_o} == 13'h0800 && !busy_o, "R1 after release", {null_sel_o, ctrl_word_o}, 13'h0800);

    // R2 first trial is null select
    target = 13'h0ABC; avg_en_i = 0; flip_en = 0; rip_period = 3;
    pulse_start();
    check(busy_o, "R2 busy", busy_o, 1);
    check({null_sel_o, ctrl_word_o} == 13'h1000, "R2 first trial", {null_sel_o, ctrl_word_o}, 13'h1000);
    wait_done("R4 R5");
    check(result_o == 13'h0ABC, "R4 result", result_o, 13'h0ABC);

    // R9 hold at null after done
    repeat (25) @(negedge clk_i);
    check({null_sel_o, ctrl_word_o} == 13'h0ABC, "R9 code held", {null_sel_o, ctrl_word_o}, 13'h0ABC);
    check(result_o == 13'h0ABC && !busy_o, "R9 result held", result_o, 13'h0ABC);

    // R4 directed corners around the null-select boundary
    convert(13'h0000, 0, 1, "R4 zero");
    convert(13'h1FFF, 0, 2, "R4 full");
    convert(13'h1000, 0, 4, "R4 upper null");
    convert(13'h0FFF, 0, 3, "R4 lower null");

    // R4 R5 random targets, random strobe spacing, off-strobe noise
    for (int n = 0; n < 8; n++) begin
      t = 13'($urandom);
      convert(t, 0, 1 + int'($urandom % 4), "R5 random");
    end

    // R6 averaging with one bad sample per window
    convert(13'h1555, 1, 2, "R6 avg");
    convert(13'h0001, 1, 1, "R6 avg low");
    for (int n = 0; n < 3; n++) begin
      t = 13'($urandom);
      convert(t, 1, 1 + int'($urandom % 3), "R6 avg random");
    end

    // R8 start during conversion
    target = 13'h0F0F; avg_en_i = 0; flip_en = 0; rip_period = 2;
    @(negedge clk_i);
    d0 = done_cnt;
    pulse_start();
    repeat (40) @(negedge clk_i);
    check(busy_o, "R8 busy mid", busy_o, 1);
    pulse_start();
    wait_done("R8");
    check(result_o == 13'h0F0F, "R8 result", result_o, 13'h0F0F);
    repeat (30) @(negedge clk_i);
    check(done_cnt == d0 + 1, "R8 single done", done_cnt - d0, 1);
    check(!busy_o, "R8 no restart", busy_o, 0);

    // R1 reset in the middle of a conversion
    target = 13'h1234;
    pulse_start();
    repeat (30) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check({null_sel_o, ctrl_word_o} == 13'h0800, "R1 mid reset code", {null_sel_o, ctrl_word_o}, 13'h0800);
    check(!busy_o && !done_o && result_o == 0, "R1 mid reset state", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    convert(13'h1234, 0, 3, "R1 R4 after reset");

    summary();
    $finish;
  end
endmodule